// File: doc/BRIEF.md
# Background Memory Scrubber with Chip Sparing

This block walks the whole memory in the background, one address at a time. For each address it issues a read. It takes the word that the error-correction path delivers, already corrected, and writes that word back to the same address, so that transient bit flips do not build up. Scrub traffic has the lowest priority on the memory port. The block only issues a request in a cycle when normal traffic leaves the port idle.

Each read response carries a correctable-error flag and the index of the symbol position (DRAM chip) that was corrected. The block keeps a saturating error count for every physical position, spare positions included. When a position in service reaches the threshold, a free spare whose own count is below the threshold is assigned to the logical chip that position serves.

Migration takes two steps:
- At the next pass boundary the spare enters a copy phase. For one full pass, writes to that chip are duplicated onto the spare.
- At the following boundary, reads are steered to the spare.

A spare that is in service can itself be replaced by another spare, and the replaced spare is retired. When no eligible spare is left, the group reports that it is exhausted.

Top module: `mem_scrubber`

## Requirements
- R1: Scrub requests alternate read then write to the same address. The address is held until the write is issued, then steps by one, wrapping from 2^ADDR_W-1 to 0 (the end of a pass). After reset the walk starts with a read of address 0.
- R2: `mem_req` is never high in a cycle where `host_busy` is high. A request that is high in a cycle counts as accepted at the following clock edge.
- R3: The write-back data `mem_wdata` equals the `rd_data` returned for the read of that same address.
- R4: A response with `rd_valid` and `rd_ce` both high adds one to the count of position `rd_sym`. Each count saturates at 2^CNT_W-1 and never wraps.
- R5: A sparing action starts when a correctable error hits a position in service and the count after the increment is at least THRESH, with no spare pending or copying. The action takes the lowest-index spare that is FREE and whose count is below THRESH, sets it to PENDING, and targets it at the logical chip that the failing position serves. Only one spare is pending or copying at a time. A trigger that arrives while one is busy is dropped.
- R6: At the next pass end a PENDING spare becomes COPYING. While a spare is COPYING, bit c of `dup_mask` is high for its target chip c.
- R7: At the next pass end a COPYING spare becomes ACTIVE. Bit c of `steer_mask` goes high for its target chip c. A spare that was ACTIVE for the same chip becomes RETIRED.
- R8: A trigger with no eligible spare sets the group status to EXHAUSTED, which stays until reset.
- R9: Positions that are not in service never trigger sparing. These are free, pending, copying or retired spares, and original chips whose reads are steered away.
- R10: Encodings. `grp_status` is 0 normal, 1 migrating (a spare pending or copying), 2 complete (at least one spare active, none busy), 3 exhausted. Exhausted has the highest priority, then migrating. Spare slot s has its state at `spare_state[3s+2:3s]` (0 FREE, 1 PENDING, 2 COPYING, 3 ACTIVE, 4 RETIRED) and its target chip at `spare_for[LW*s+LW-1:LW*s]`, where LW = clog2(NSYM). Positions 0..NSYM-1 are the original chips and position NSYM+s is spare slot s. Reset gives status 0, all slots FREE and both masks zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_busy | input | 1 | Normal traffic owns the memory port this cycle |
| mem_req | output | 1 | Scrub request valid |
| mem_we | output | 1 | Request is a write (1) or a read (0) |
| mem_addr | output | ADDR_W | Scrub address |
| mem_wdata | output | DATA_W | Corrected write-back data |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | DATA_W | Corrected read data |
| rd_ce | input | 1 | Response contained a corrected error |
| rd_sym | input | clog2(NSYM+NSPARE) | Physical position of the corrected symbol |
| dup_mask | output | NSYM | Chips whose writes are duplicated onto a copying spare |
| steer_mask | output | NSYM | Chips whose reads come from an active spare |
| spare_state | output | 3*NSPARE | Per-slot spare state |
| spare_for | output | NSPARE*clog2(NSYM) | Per-slot target chip |
| grp_status | output | 2 | Group sparing status |

## Verification
The assertions assume that `rd_valid` arrives only for a read the block issued, and that the requester drives `host_busy` from a clock edge, so a request seen in a cycle is granted at the next edge. The bench's memory model answers only the scrubber's reads, one cycle after the grant. It changes `host_busy` just after each rising edge, pseudo-randomly in the walking phase and held low during the sparing sequence. Error injections are always attached to a real read response. The trigger that opens the first migration is lined up with a read of address 0, so the pass boundaries fall at known points.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
   typedef enum logic [2:0] {
      SP_FREE    = 3'd0,
      SP_PEND    = 3'd1,
      SP_COPY    = 3'd2,
      SP_ACTIVE  = 3'd3,
      SP_RETIRED = 3'd4
   } spare_st_e;

   typedef enum logic [1:0] {
      GS_NORMAL    = 2'd0,
      GS_MIGRATING = 2'd1,
      GS_COMPLETE  = 2'd2,
      GS_EXHAUSTED = 2'd3
   } grp_st_e;

   typedef enum logic [1:0] {
      SQ_RD   = 2'd0,
      SQ_WAIT = 2'd1,
      SQ_WR   = 2'd2
   } seq_st_e;
endpackage

// File: rtl/scrub_walker.sv
module scrub_walker
   import scrub_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 72
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_busy,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              rd_take,
   output logic              pass_end
);
   localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

   seq_st_e           st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] hold_q;
   logic              issue;

   assign issue     = !host_busy && (st_q == SQ_RD || st_q == SQ_WR);
   assign mem_req   = issue;
   assign mem_we    = (st_q == SQ_WR);
   assign mem_addr  = addr_q;
   assign mem_wdata = hold_q;
   assign rd_take   = (st_q == SQ_WAIT) && rd_valid;
   assign pass_end  = issue && (st_q == SQ_WR) && (addr_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_RD;
         addr_q <= '0;
         hold_q <= '0;
      end else begin
         case (st_q)
            SQ_RD:   if (!host_busy) st_q <= SQ_WAIT;
            SQ_WAIT: if (rd_valid) begin
               hold_q <= rd_data;
               st_q   <= SQ_WR;
            end
            SQ_WR:   if (!host_busy) begin
               st_q   <= SQ_RD;
               addr_q <= addr_q + 1'b1;
            end
            default: st_q <= SQ_RD;
         endcase
      end
   end
endmodule

// File: rtl/sym_err_counters.sv
module sym_err_counters #(
   parameter int NPOS   = 20,
   parameter int CNT_W  = 8,
   parameter int THRESH = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ce_evt,
   input  logic [$clog2(NPOS)-1:0]  ce_pos,
   output logic [NPOS*CNT_W-1:0]    cnt_flat,
   output logic [NPOS-1:0]          hot_vec,
   output logic                     ce_hot
);
   localparam int               PW   = $clog2(NPOS);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] TH   = CNT_W'(THRESH);
   localparam logic [CNT_W-1:0] TH1  = CNT_W'(THRESH - 1);

   for (genvar p = 0; p < NPOS; p++) begin : g_pos
      logic [CNT_W-1:0] c_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            c_q <= '0;
         else if (ce_evt && ce_pos == PW'(p) && c_q != CMAX)
            c_q <= c_q + 1'b1;
      end
      assign cnt_flat[p*CNT_W +: CNT_W] = c_q;
      assign hot_vec[p] = (c_q >= TH);
   end

   // saturated (count + 1) >= THRESH is the same as count >= THRESH - 1
   always_comb begin
      ce_hot = 1'b0;
      for (int p = 0; p < NPOS; p++)
         if (ce_pos == PW'(p)) ce_hot = (cnt_flat[p*CNT_W +: CNT_W] >= TH1);
   end
endmodule

// File: rtl/spare_mapper.sv
module spare_mapper
   import scrub_pkg::*;
#(
   parameter int NSYM   = 18,
   parameter int NSPARE = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                ce_evt,
   input  logic [$clog2(NSYM+NSPARE)-1:0]      ce_pos,
   input  logic                                ce_hot,
   input  logic [NSYM+NSPARE-1:0]              hot_vec,
   input  logic                                pass_end,
   output logic [NSYM-1:0]                     dup_mask,
   output logic [NSYM-1:0]                     steer_mask,
   output logic [3*NSPARE-1:0]                 spare_state,
   output logic [NSPARE*$clog2(NSYM)-1:0]      spare_for,
   output logic [1:0]                          grp_status
);
   localparam int PW = $clog2(NSYM + NSPARE);
   localparam int LW = $clog2(NSYM);

   spare_st_e         st_q  [NSPARE];
   logic [LW-1:0]     tgt_q [NSPARE];
   logic              exhausted_q;

   logic              busy, copying, any_act, svc, found, trigger;
   logic [LW-1:0]     copy_tgt, lchip;
   int                pick;

   always_comb begin
      dup_mask   = '0;
      steer_mask = '0;
      busy       = 1'b0;
      copying    = 1'b0;
      any_act    = 1'b0;
      copy_tgt   = '0;
      for (int s = 0; s < NSPARE; s++) begin
         if (st_q[s] == SP_PEND) busy = 1'b1;
         if (st_q[s] == SP_COPY) begin
            busy     = 1'b1;
            copying  = 1'b1;
            copy_tgt = tgt_q[s];
         end
         if (st_q[s] == SP_ACTIVE) any_act = 1'b1;
         for (int c = 0; c < NSYM; c++) begin
            if (tgt_q[s] == LW'(c) && st_q[s] == SP_COPY)   dup_mask[c]   = 1'b1;
            if (tgt_q[s] == LW'(c) && st_q[s] == SP_ACTIVE) steer_mask[c] = 1'b1;
         end
      end
   end

   // is the failing position serving a logical chip, and which one
   always_comb begin
      svc   = 1'b0;
      lchip = '0;
      for (int c = 0; c < NSYM; c++)
         if (ce_pos == PW'(c)) begin
            svc   = !steer_mask[c];
            lchip = LW'(c);
         end
      for (int s = 0; s < NSPARE; s++)
         if (ce_pos == PW'(NSYM + s) && st_q[s] == SP_ACTIVE) begin
            svc   = 1'b1;
            lchip = tgt_q[s];
         end
   end

   // lowest-index free spare that is not itself error-prone
   always_comb begin
      found = 1'b0;
      pick  = 0;
      for (int s = NSPARE - 1; s >= 0; s--)
         if (st_q[s] == SP_FREE && !hot_vec[NSYM + s]) begin
            found = 1'b1;
            pick  = s;
         end
   end

   assign trigger = ce_evt && ce_hot && svc && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NSPARE; s++) begin
            st_q[s]  <= SP_FREE;
            tgt_q[s] <= '0;
         end
         exhausted_q <= 1'b0;
      end else begin
         for (int s = 0; s < NSPARE; s++) begin
            if (pass_end) begin
               case (st_q[s])
                  SP_PEND:   st_q[s] <= SP_COPY;
                  SP_COPY:   st_q[s] <= SP_ACTIVE;
                  SP_ACTIVE: if (copying && tgt_q[s] == copy_tgt) st_q[s] <= SP_RETIRED;
                  default:   ;
               endcase
            end
            if (trigger && found && pick == s) begin
               st_q[s]  <= SP_PEND;
               tgt_q[s] <= lchip;
            end
         end
         if (trigger && !found) exhausted_q <= 1'b1;
      end
   end

   for (genvar s = 0; s < NSPARE; s++) begin : g_out
      assign spare_state[3*s +: 3]  = st_q[s];
      assign spare_for[LW*s +: LW]  = tgt_q[s];
   end

   assign grp_status = exhausted_q ? GS_EXHAUSTED :
                       busy        ? GS_MIGRATING :
                       any_act     ? GS_COMPLETE  : GS_NORMAL;
endmodule

// File: rtl/mem_scrubber.sv
module mem_scrubber #(
   parameter int DATA_W = 72,
   parameter int ADDR_W = 10,
   parameter int NSYM   = 18,
   parameter int NSPARE = 2,
   parameter int CNT_W  = 8,
   parameter int THRESH = 16
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                host_busy,
   output logic                                mem_req,
   output logic                                mem_we,
   output logic [ADDR_W-1:0]                   mem_addr,
   output logic [DATA_W-1:0]                   mem_wdata,
   input  logic                                rd_valid,
   input  logic [DATA_W-1:0]                   rd_data,
   input  logic                                rd_ce,
   input  logic [$clog2(NSYM+NSPARE)-1:0]      rd_sym,
   output logic [NSYM-1:0]                     dup_mask,
   output logic [NSYM-1:0]                     steer_mask,
   output logic [3*NSPARE-1:0]                 spare_state,
   output logic [NSPARE*$clog2(NSYM)-1:0]      spare_for,
   output logic [1:0]                          grp_status
);
   localparam int NPOS = NSYM + NSPARE;

   if (NSYM < 2) begin : g_bad_nsym
      $error("mem_scrubber: NSYM must be at least 2");
   end
   if (NSPARE < 1) begin : g_bad_nspare
      $error("mem_scrubber: NSPARE must be at least 1");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("mem_scrubber: ADDR_W and DATA_W must be positive");
   end
   if (THRESH < 1 || THRESH > (2**CNT_W) - 1) begin : g_bad_thresh
      $error("mem_scrubber: THRESH must lie in 1 .. 2**CNT_W-1");
   end

   logic                  rd_take, pass_end, ce_hot;
   logic [NPOS*CNT_W-1:0] cnt_flat;
   logic [NPOS-1:0]       hot_vec;

   scrub_walker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .host_busy(host_busy),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .rd_take(rd_take), .pass_end(pass_end)
   );

   sym_err_counters #(.NPOS(NPOS), .CNT_W(CNT_W), .THRESH(THRESH)) u_cnt (
      .clk(clk), .rst_n(rst_n), .ce_evt(rd_take && rd_ce), .ce_pos(rd_sym),
      .cnt_flat(cnt_flat), .hot_vec(hot_vec), .ce_hot(ce_hot)
   );

   spare_mapper #(.NSYM(NSYM), .NSPARE(NSPARE)) u_map (
      .clk(clk), .rst_n(rst_n), .ce_evt(rd_take && rd_ce), .ce_pos(rd_sym),
      .ce_hot(ce_hot), .hot_vec(hot_vec), .pass_end(pass_end),
      .dup_mask(dup_mask), .steer_mask(steer_mask),
      .spare_state(spare_state), .spare_for(spare_for),
      .grp_status(grp_status)
   );
endmodule

// File: rtl/mem_scrubber_chk.sv
module mem_scrubber_chk #(
   parameter int ADDR_W = 10,
   parameter int NSYM   = 18,
   parameter int NPOS   = 20,
   parameter int CNT_W  = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  host_busy,
   input logic                  mem_req,
   input logic                  mem_we,
   input logic [ADDR_W-1:0]     mem_addr,
   input logic [NSYM-1:0]       dup_mask,
   input logic [NSYM-1:0]       steer_mask,
   input logic [1:0]            grp_status,
   input logic [NPOS*CNT_W-1:0] cnt_flat
);
   a_r2_yield_to_host: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !host_busy);

   a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && mem_we) |=> $stable(mem_addr));

   a_r6_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dup_mask));

   a_r6_dup_only_migrating: assert property (@(posedge clk) disable iff (!rst_n)
      (dup_mask != '0) |-> (grp_status == 2'd1));

   a_r7_steer_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((steer_mask & $past(steer_mask)) == $past(steer_mask)));

   a_r8_exhaust_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_status == 2'd3) |=> (grp_status == 2'd3));

   for (genvar p = 0; p < NPOS; p++) begin : g_sat
      a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_flat[p*CNT_W +: CNT_W] == {CNT_W{1'b1}})
         |=> (cnt_flat[p*CNT_W +: CNT_W] == {CNT_W{1'b1}}));
   end
endmodule

bind mem_scrubber mem_scrubber_chk #(
   .ADDR_W(ADDR_W), .NSYM(NSYM), .NPOS(NSYM + NSPARE), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_busy(host_busy), .mem_req(mem_req),
   .mem_we(mem_we), .mem_addr(mem_addr), .dup_mask(dup_mask),
   .steer_mask(steer_mask), .grp_status(grp_status), .cnt_flat(cnt_flat)
);

// File: tb/mem_scrubber_test.sv
`timescale 1ns/1ps
module mem_scrubber_test;
   localparam int DATA_W = 16, ADDR_W = 2, NSYM = 4, NSPARE = 4, CNT_W = 2, THRESH = 3;
   localparam int PW = $clog2(NSYM + NSPARE);
   localparam int LW = $clog2(NSYM);

   logic clk = 0, rst_n = 0, host_busy = 0;
   logic mem_req, mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata;
   logic rd_valid = 0, rd_ce = 0;
   logic [DATA_W-1:0] rd_data = '0;
   logic [PW-1:0] rd_sym = '0;
   logic [NSYM-1:0] dup_mask, steer_mask;
   logic [3*NSPARE-1:0] spare_state;
   logic [NSPARE*LW-1:0] spare_for;
   logic [1:0] grp_status;

   int checks = 0, errors = 0, cyc = 0, passes = 0;
   int inj_req = 0, inj_done = 0;
   logic [PW-1:0] inj_sym = '0;
   logic busy_en = 0;
   logic [7:0] lfsr = 8'h5B;
   logic [ADDR_W-1:0] exp_addr = '0;
   logic exp_we = 0;

   always #2.5 clk = ~clk;

   mem_scrubber #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NSYM(NSYM), .NSPARE(NSPARE),
                  .CNT_W(CNT_W), .THRESH(THRESH)) uut (.*);

   function automatic logic [DATA_W-1:0] pat(logic [ADDR_W-1:0] a);
      return 16'h1357 * ({14'd0, a} + 16'd1);
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic expect_slot(string tag, int s, int st, int tg);
      check({tag, " slot state"}, int'(spare_state[3*s +: 3]), st);
      if (st != 0) check({tag, " slot target"}, int'(spare_for[LW*s +: LW]), tg);
   endtask

   // host traffic changes just after each rising edge
   always @(posedge clk) begin
      #1;
      host_busy = busy_en ? lfsr[0] : 1'b0;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
   end

   // memory model: one-cycle read latency, optional injected corrected error
   always @(posedge clk) begin
      if (rst_n && mem_req && !mem_we) begin
         rd_valid <= 1'b1;
         rd_data  <= pat(mem_addr);
         if (inj_req != inj_done) begin
            rd_ce    <= 1'b1;
            rd_sym   <= inj_sym;
            inj_done <= inj_done + 1;
         end else rd_ce <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         rd_ce    <= 1'b0;
      end
   end

   // request monitor: R1 ordering, R2 yield, R3 data
   always @(negedge clk) begin
      if (rst_n && mem_req) begin
         check("R2 request while host busy", int'(host_busy), 0);
         check("R1 read/write order", int'(mem_we), int'(exp_we));
         check("R1 address", int'(mem_addr), int'(exp_addr));
         if (mem_we) begin
            check("R3 write-back data", int'(mem_wdata), int'(pat(exp_addr)));
            if (exp_addr == {ADDR_W{1'b1}}) passes++;
            exp_addr = exp_addr + 1'b1;
         end
         exp_we = ~exp_we;
      end
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
         finish_run();
      end
   end

   task automatic inject(int p, bit at0);
      if (at0) while (!(mem_req && !mem_we && mem_addr == '0)) @(negedge clk);
      inj_sym = PW'(p);
      inj_req++;
      while (inj_req != inj_done) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic wait_passes(int n);
      int start;
      start = passes;
      while (passes < start + n) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 reset status", int'(grp_status), 0);
      check("R10 reset dup", int'(dup_mask), 0);
      check("R10 reset steer", int'(steer_mask), 0);
      check("R10 reset slots", int'(spare_state), 0);
      rst_n = 1;

      // R1 R2 R3 walk under pseudo-random host traffic
      busy_en = 1;
      wait_passes(3);
      busy_en = 0;
      @(negedge clk);
      check("R1 passes completed", int'(passes >= 3), 1);

      // R9 errors on a free spare never trigger; makes slot 0 ineligible
      for (int i = 0; i < 3; i++) inject(4, 0);
      check("R9 free spare errors", int'(grp_status), 0);
      expect_slot("R9", 0, 0, 0);

      // R5 below threshold then crossing, lowest eligible slot is 1
      inject(1, 0);
      inject(1, 0);
      check("R5 below threshold", int'(grp_status), 0);
      inject(1, 1);
      check("R5 migrating status", int'(grp_status), 1);
      expect_slot("R5 pick", 1, 1, 1);
      expect_slot("R5 hot spare skipped", 0, 0, 0);
      check("R6 no dup while pending", int'(dup_mask), 0);

      // R5 busy: chip 2 reaches threshold but no new action
      for (int i = 0; i < 3; i++) inject(2, 0);
      expect_slot("R5 busy drop", 2, 0, 0);
      check("R5 busy status", int'(grp_status), 1);

      wait_passes(1);
      expect_slot("R6 copy", 1, 2, 1);
      check("R6 dup mask", int'(dup_mask), 4'b0010);
      check("R6 steer during copy", int'(steer_mask), 0);
      inject(2, 0);   // fourth error: counter must hold at max (R4)
      expect_slot("R4 still busy", 2, 0, 0);

      wait_passes(1);
      expect_slot("R7 active", 1, 3, 1);
      check("R7 steer mask", int'(steer_mask), 4'b0010);
      check("R7 dup cleared", int'(dup_mask), 0);
      check("R10 complete status", int'(grp_status), 2);

      // R9 replaced original chip no longer triggers
      inject(1, 0);
      check("R9 steered chip", int'(grp_status), 2);
      expect_slot("R9 steered chip", 2, 0, 0);

      // R4 saturated count (not wrapped) triggers on next error
      inject(2, 0);
      expect_slot("R4 saturated trigger", 2, 1, 2);
      wait_passes(2);
      expect_slot("R7 second active", 2, 3, 2);
      check("R7 steer two chips", int'(steer_mask), 4'b0110);

      // R7 spare of a spare: slot 1 (position 5) replaced by slot 3
      for (int i = 0; i < 3; i++) inject(5, 0);
      expect_slot("R5 spare replaced", 3, 1, 1);
      wait_passes(1);
      expect_slot("R6 spare copy", 3, 2, 1);
      check("R6 dup spare", int'(dup_mask), 4'b0010);
      check("R7 old spare still steers", int'(steer_mask), 4'b0110);
      wait_passes(1);
      expect_slot("R7 new spare", 3, 3, 1);
      expect_slot("R7 old retired", 1, 4, 1);
      check("R7 steer kept", int'(steer_mask), 4'b0110);
      check("R10 complete again", int'(grp_status), 2);

      // R9 retired spare ignored
      inject(5, 0);
      check("R9 retired spare", int'(grp_status), 2);

      // R8 no eligible spare left
      for (int i = 0; i < 3; i++) inject(3, 0);
      check("R8 exhausted", int'(grp_status), 3);
      expect_slot("R8 hot spare unused", 0, 0, 0);
      wait_passes(1);
      check("R8 sticky", int'(grp_status), 3);
      check("R8 steer unchanged", int'(steer_mask), 4'b0110);

      finish_run();
   end
endmodule